// File: doc/BRIEF.md
# GPIO Controller with Change Interrupts

This block is a memory-mapped general-purpose I/O controller for up to 32 lines, reached over a 32-bit register bus with an APB-like select/enable handshake. Each line can be made an output or an input, has its own output data bit and can have its level read back. Writes to the output data are filtered by a write-mask register, so that software can change chosen lines without a read-modify-write.

Every input line is brought into the clock domain through a two-stage synchroniser. Any rising or falling transition seen on an input line sets a sticky per-line change bit. Software acknowledges a change by writing one to that bit. A per-line enable decides which change bits drive a single combined interrupt output. The bus has no wait states: a write takes effect at the clock edge that ends its access cycle, and read data is valid during the access cycle. The block has no streaming data path, so there is no valid/ready handshake; every pin is a plain control or status signal.

Register words (byte offsets, low two address bits ignored): 0x00 line direction, 0x04 line data, 0x08 change-interrupt enable, 0x0C change flags, 0x10 data write mask, 0x14 spare trigger-kind word. Offsets 0x18 and 0x1C are unmapped.

Top module: `gpio_chg_ctrl`

## Requirements
- R1: After reset, direction, output data, enable and change flags read as zero, the write mask reads as all ones over the implemented lines, the trigger-kind word reads zero, pin_oe and pin_out are zero and irq is low.
- R2: A bus write to offset 0x00 sets the direction word; bit n = 1 makes line n an output, and pin_oe equals the direction word from the clock edge that completes the write.
- R3: A bus write to offset 0x04 changes only the output data bits whose write-mask bit (offset 0x10) is 1; the others keep their value, and pin_out shows the output data word.
- R4: A read of offset 0x04 returns, for each output line, its output data bit, and for each input line the pin level captured two clock edges after the pin changed.
- R5: A rising or a falling transition on an input line sets that line's change flag (offset 0x0C) three clock edges after the pin changes; a transition on an output line sets no flag.
- R6: Writing 1 to a change flag bit clears it; writing 0 leaves it unchanged.
- R7: When a new transition and a clearing write meet on the same flag in the same cycle, the flag stays set.
- R8: irq is high exactly when some line has both its change flag and its enable bit (offset 0x08) set.
- R9: Bits at and above N_LINES read as zero in every register and writes to them have no effect.
- R10: The trigger-kind word at 0x14 reads back what was written and has no effect on behaviour; unmapped offsets read zero and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus select |
| bus_en | input | 1 | Access phase strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| pin_in | input | N_LINES | Pad input levels, asynchronous |
| pin_out | output | N_LINES | Output data to the pads |
| pin_oe | output | N_LINES | Output enable per line |
| irq | output | 1 | Combined change interrupt |

## Verification
The assertions assume that pin_in is held steady during reset, so the synchroniser and the previous-level register start in agreement with the pads and no change is invented at reset release; the stimulus keeps all pins low until reset ends. They also assume that bus inputs are stable around the clock edge, which the stimulus meets by driving every bus and pin signal on the falling edge. Pin changes are spaced, and one case deliberately lines a transition up with a clearing write to the same flag.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
  localparam int BUS_W  = 32;
  localparam int OFFS_W = 5;
  localparam int SEL_W  = OFFS_W - 2;

  // word select decoded from the byte offset
  typedef enum logic [SEL_W-1:0] {
    SEL_DIR   = 3'd0,
    SEL_DATA  = 3'd1,
    SEL_IEN   = 3'd2,
    SEL_CHG   = 3'd3,
    SEL_WMASK = 3'd4,
    SEL_KIND  = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/gpio_chg_sync.sv
module gpio_chg_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-2:0], d};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q[0] <= d;
      end
    end
  endgenerate

  assign q = stg_q[LAST];
endmodule

// File: rtl/gpio_chg_capture.sv
module gpio_chg_capture #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] watch,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] flags_q,
  output logic [WIDTH-1:0] edge_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  // any difference from last cycle counts, in either direction
  assign edge_o = (level ^ prev_q) & watch;

  // set beats clear on the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr) | edge_o;
  end
endmodule

// File: rtl/gpio_chg_regs.sv
module gpio_chg_regs
  import gpio_chg_pkg::*;
#(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [OFFS_W-1:0]  addr,
  input  logic [BUS_W-1:0]   wdata,
  input  logic [N_LINES-1:0] sync_lvl,
  input  logic [N_LINES-1:0] chg,
  output logic [N_LINES-1:0] dir_q,
  output logic [N_LINES-1:0] out_q,
  output logic [N_LINES-1:0] ien_q,
  output logic [N_LINES-1:0] wmask_q,
  output logic [N_LINES-1:0] w1c,
  output logic [BUS_W-1:0]   rdata
);
  logic [BUS_W-1:0]   kind_q;
  logic [N_LINES-1:0] wd;
  logic [N_LINES-1:0] level;
  reg_sel_e           sel;

  assign sel = reg_sel_e'(addr[OFFS_W-1:2]);
  assign wd  = wdata[N_LINES-1:0];

  function automatic logic [BUS_W-1:0] widen(input logic [N_LINES-1:0] v);
    logic [BUS_W-1:0] r;
    r = '0;
    r[N_LINES-1:0] = v;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      ien_q   <= '0;
      wmask_q <= '1;
      kind_q  <= '0;
    end else if (wr) begin
      case (sel)
        SEL_DIR:   dir_q   <= wd;
        SEL_DATA:  out_q   <= (out_q & ~wmask_q) | (wd & wmask_q);
        SEL_IEN:   ien_q   <= wd;
        SEL_WMASK: wmask_q <= wd;
        SEL_KIND:  kind_q  <= wdata;
        default:   ;
      endcase
    end
  end

  assign w1c = (wr && sel == SEL_CHG) ? wd : '0;

  // output lines read their driven value, input lines their pad level
  assign level = (dir_q & out_q) | (~dir_q & sync_lvl);

  always_comb begin
    case (sel)
      SEL_DIR:   rdata = widen(dir_q);
      SEL_DATA:  rdata = widen(level);
      SEL_IEN:   rdata = widen(ien_q);
      SEL_CHG:   rdata = widen(chg);
      SEL_WMASK: rdata = widen(wmask_q);
      SEL_KIND:  rdata = kind_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_chg_ctrl.sv
module gpio_chg_ctrl
  import gpio_chg_pkg::*;
#(
  parameter int N_LINES     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [4:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [N_LINES-1:0] pin_in,
  output logic [N_LINES-1:0] pin_out,
  output logic [N_LINES-1:0] pin_oe,
  output logic               irq
);
  logic               wr;
  logic [N_LINES-1:0] sync_lvl;
  logic [N_LINES-1:0] dir_q, out_q, ien_q, wmask_q, w1c;
  logic [N_LINES-1:0] chg_q, edge_vec;

  assign wr = bus_sel & bus_en & bus_we;

  gpio_chg_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (sync_lvl)
  );

  gpio_chg_capture #(.WIDTH(N_LINES)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (sync_lvl),
    .watch   (~dir_q),
    .clr     (w1c),
    .flags_q (chg_q),
    .edge_o  (edge_vec)
  );

  gpio_chg_regs #(.N_LINES(N_LINES)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .sync_lvl (sync_lvl),
    .chg      (chg_q),
    .dir_q    (dir_q),
    .out_q    (out_q),
    .ien_q    (ien_q),
    .wmask_q  (wmask_q),
    .w1c      (w1c),
    .rdata    (bus_rdata)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |(chg_q & ien_q);
endmodule

// File: rtl/gpio_chg_chk.sv
module gpio_chg_chk #(
  parameter int N_LINES = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr,
  input logic [4:0]         bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [N_LINES-1:0] pin_oe,
  input logic [N_LINES-1:0] pin_out,
  input logic [N_LINES-1:0] wmask_q,
  input logic [N_LINES-1:0] ien_q,
  input logic [N_LINES-1:0] chg_q,
  input logic [N_LINES-1:0] edge_vec,
  input logic               irq
);
  logic wr_dir, wr_data, wr_chg;
  assign wr_dir  = wr && bus_addr[4:2] == 3'd0;
  assign wr_data = wr && bus_addr[4:2] == 3'd1;
  assign wr_chg  = wr && bus_addr[4:2] == 3'd3;

  // R2
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(pin_oe));

  // R3
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pin_out ^ $past(pin_out)) & ~$past(wmask_q)) == '0);

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data |=> $stable(pin_out));

  // R5
  chg_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (chg_q & ~$past(chg_q) & ~$past(edge_vec)) == '0);

  // R5
  out_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_vec & pin_oe) == '0);

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_chg |=> (chg_q & $past(bus_wdata[N_LINES-1:0] & ~edge_vec)) == '0);

  // R7
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_vec) |=> (chg_q & $past(edge_vec)) == $past(edge_vec));

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);
endmodule

bind gpio_chg_ctrl gpio_chg_chk #(.N_LINES(N_LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr        (wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out),
  .wmask_q   (wmask_q),
  .ien_q     (ien_q),
  .chg_q     (chg_q),
  .edge_vec  (edge_vec),
  .irq       (irq)
);

// File: tb/tb_gpio_chg_ctrl.sv
module tb_gpio_chg_ctrl;
  localparam int N = 24;
  localparam logic [31:0] LMASK = 32'h00FF_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 0, bus_en = 0, bus_we = 0;
  logic [4:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out, pin_oe;
  logic          irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_chg_ctrl #(.N_LINES(N)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_en(bus_en),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [N-1:0] m_dir, m_out, m_en, m_chg, m_wm;
  logic [31:0]  m_kind;
  logic [N-1:0] hist[$];   // hist[0] = pin sampled at the latest edge

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = '0; m_out = '0; m_en = '0; m_chg = '0; m_wm = '1; m_kind = '0;
      hist = {};
      for (int i = 0; i < 3; i++) hist.push_back('0);
    end else begin
      logic [N-1:0] trans, nd, no, ne, nc, nw, clr;
      logic [31:0]  nk;
      trans = (hist[1] ^ hist[2]) & ~m_dir;
      nd = m_dir; no = m_out; ne = m_en; nw = m_wm; nk = m_kind; clr = '0;
      if (bus_sel && bus_en && bus_we) begin
        case (bus_addr >> 2)
          0: nd = bus_wdata[N-1:0];
          1: for (int b = 0; b < N; b++) if (m_wm[b]) no[b] = bus_wdata[b];
          2: ne = bus_wdata[N-1:0];
          3: clr = bus_wdata[N-1:0];
          4: nw = bus_wdata[N-1:0];
          5: nk = bus_wdata;
          default: ;
        endcase
      end
      nc = m_chg;
      for (int b = 0; b < N; b++) begin
        if (clr[b]) nc[b] = 1'b0;
        if (trans[b]) nc[b] = 1'b1;
      end
      m_dir = nd; m_out = no; m_en = ne; m_chg = nc; m_wm = nw; m_kind = nk;
      hist.push_front(pin_in);
      void'(hist.pop_back());
    end
  end

  function automatic logic [31:0] model_rd(input logic [4:0] a);
    logic [N-1:0] lv;
    lv = (m_dir & m_out) | (~m_dir & hist[1]);
    case (a >> 2)
      0: return {8'h0, m_dir};
      1: return {8'h0, lv};
      2: return {8'h0, m_en};
      3: return {8'h0, m_chg};
      4: return {8'h0, m_wm};
      5: return m_kind;
      default: return 32'h0;
    endcase
  endfunction

  // ---------------- per-clock comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq !== |(m_chg & m_en)) begin
        errors++;
        $display("FAIL R8 irq actual=%0b expected=%0b", irq, |(m_chg & m_en));
      end
      checks++;
      if (pin_oe !== m_dir) begin
        errors++;
        $display("FAIL R2 pin_oe actual=%h expected=%h", pin_oe, m_dir);
      end
      checks++;
      if (pin_out !== m_out) begin
        errors++;
        $display("FAIL R3 pin_out actual=%h expected=%h", pin_out, m_out);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_en = 0; bus_we = 0;
  endtask

  // read and compare against model and against a stated value
  task automatic rd(input string tag, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1; bus_en = 1; bus_we = 0; bus_addr = a;
    #1;
    check(tag, bus_rdata, model_rd(a));
    check(tag, bus_rdata, exp);
    @(negedge clk);
    bus_sel = 0; bus_en = 0;
  endtask

  task automatic pins(input logic [N-1:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 oe", {8'h0, pin_oe}, 32'h0);
    rd("R1 dir", 5'h00, 32'h0);
    rd("R1 data", 5'h04, 32'h0);
    rd("R1 ien", 5'h08, 32'h0);
    rd("R1 chg", 5'h0C, 32'h0);
    rd("R1 R9 wmask", 5'h10, LMASK);
    rd("R1 kind", 5'h14, 32'h0);

    // R2 direction
    wr(5'h00, 32'h0000_00FF);
    rd("R2 dir", 5'h00, 32'h0000_00FF);
    check("R2 oe", {8'h0, pin_oe}, 32'h0000_00FF);

    // R3 / R4 data write, full mask
    wr(5'h04, 32'h00A5_A5A5);
    check("R3 pin_out", {8'h0, pin_out}, 32'h00A5_A5A5);
    rd("R4 data mixed", 5'h04, 32'h0000_00A5);

    // R3 masked write
    wr(5'h10, 32'h0000_000F);
    wr(5'h04, 32'hFFFF_FFFF);
    check("R3 masked", {8'h0, pin_out}, 32'h00A5_A5AF);
    wr(5'h10, 32'hFFFF_FFFF);

    // R4 input level latency: one edge later old, two edges later new
    pins(24'h00_0300);
    rd("R4 level after 1 edge", 5'h04, 32'h0000_00AF);
    rd("R4 level after 2 edges", 5'h04, 32'h0000_03AF);

    // R5 rising edges captured
    idle(2);
    rd("R5 rise", 5'h0C, 32'h0000_0300);

    // R6 write zero keeps, write one clears
    wr(5'h0C, 32'h0000_0000);
    rd("R6 zero write", 5'h0C, 32'h0000_0300);
    wr(5'h0C, 32'h0000_0100);
    rd("R6 clear", 5'h0C, 32'h0000_0200);

    // R5 falling edge on line 8
    pins(24'h00_0200);
    idle(3);
    rd("R5 fall", 5'h0C, 32'h0000_0300);

    // R8 interrupt enable
    wr(5'h08, 32'h0000_0100);
    check("R8 irq on", {31'h0, irq}, 32'h1);
    wr(5'h0C, 32'h0000_0100);
    check("R8 irq off", {31'h0, irq}, 32'h0);

    // R5 output line transitions ignored
    pins(24'h00_0203);
    idle(4);
    rd("R5 out lines", 5'h0C, 32'h0000_0200);

    // R7 transition coincides with clearing write on line 9
    pins(24'h00_0003);
    @(negedge clk);
    wr(5'h0C, 32'h0000_0200);
    rd("R7 edge wins", 5'h0C, 32'h0000_0200);
    wr(5'h0C, 32'h0000_0200);
    rd("R7 later clear", 5'h0C, 32'h0000_0000);

    // R9 upper bits
    wr(5'h08, 32'hFFFF_FFFF);
    rd("R9 ien", 5'h08, LMASK);
    pins(24'h80_0003);
    idle(3);
    rd("R9 R5 top line", 5'h0C, 32'h0080_0000);
    check("R8 R9 irq", {31'h0, irq}, 32'h1);
    wr(5'h0C, 32'hFFFF_FFFF);

    // R10 spare word and unmapped offsets
    wr(5'h14, 32'hDEAD_0005);
    rd("R10 kind", 5'h14, 32'hDEAD_0005);
    wr(5'h18, 32'hFFFF_FFFF);
    rd("R10 unmapped", 5'h18, 32'h0);
    rd("R10 dir kept", 5'h00, 32'h0000_00FF);
    rd("R10 ien kept", 5'h08, LMASK);
    rd("R10 chg kept", 5'h0C, 32'h0);
    check("R10 pins kept", {8'h0, pin_out}, 32'h00A5_A5AF);

    // R4 more input patterns
    wr(5'h00, 32'h0);
    pins(24'h5A_C3F0);
    idle(2);
    rd("R4 pattern", 5'h04, 32'h005A_C3F0);
    idle(2);
    rd("R5 multi", 5'h0C, 32'h00DA_C3F3);

    idle(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired, actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule